// File: doc/BRIEF.md
# Open-String Latch-Off Diagnostic Controller

This block is the digital policy layer that sits on an eight-channel LED current driver. The analog sensing has already been reduced to flags: one open-string flag per channel, a flag for an open chained sequence output, a thermal flag and a bias (current-limit) flag, plus supply-state flags. From these the block produces one output-kill signal for all channels and one diagnostic flag.

An open string has to persist for a programmable number of millisecond ticks before it counts. Detection is idle while the supply is below the open-load threshold. Channels that read as grounded when the supply first crosses that threshold are masked until the next power-down. With the latch-off option selected (`latch_off_n` low), one qualified open string kills all outputs and keeps them off. The kill state clears on a diagnostic reset request, on any edge of `enable_n`, or on an under-voltage power-down. Each clear restarts qualification. In stop mode the diagnostic flag is a steady level. In tail mode an open-string report is shown only while the PWM on-phase is active.

Both outputs are registered, so each follows its inputs after one clock edge.

Top module: `openstring_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `all_off` = 1 and `diag_high` = 1.
- R2: While `enable_n` = 1, `all_off` = 1 and `diag_high` = 1, whatever the fault flags are.
- R3: An open flag counts only after it has stayed high for QUAL_TICKS ticks of a TICK_DIV-cycle prescaler. It is not reported within (QUAL_TICKS-1)*TICK_DIV cycles and is reported by QUAL_TICKS*TICK_DIV+4 cycles. If the flag drops at any point, qualification starts again from zero.
- R4: While `supply_ok` = 0, open flags have no effect on either output.
- R5: A channel whose `chan_grounded` bit is 1 on the cycle `supply_ok` is first seen high after power-up is masked from open detection. The mask is kept until `uvlo` is asserted, and `uvlo` re-arms the capture.
- R6: With `latch_off_n` = 0, a qualified open string sets `all_off` = 1 and `diag_high` = 1. Both stay set after the open flag goes away.
- R7: With `latch_off_n` = 1, a qualified open string sets `diag_high` = 1 while `all_off` stays 0.
- R8: A one-cycle `diag_reset` clears the latched state. If the open string persists, it must qualify again before the outputs are latched off again.
- R9: A toggle of `enable_n` clears the latched state.
- R10: Asserting `uvlo` clears the latched state.
- R11: With `stop` = 1 a reported open string holds `diag_high` steady at 1. With `stop` = 0 the report follows `pwm_on` (1 during the on-phase, 0 during the off-phase).
- R12: `thermal` = 1 sets both `all_off` and `diag_high`. `bias_fault` = 1 sets only `diag_high`.
- R13: `chain_open` is qualified and acted on like a channel open string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_n | input | 1 | Global enable, low turns the driver on |
| latch_off_n | input | 1 | Low selects latch-off on an open string |
| stop | input | 1 | 1 = stop mode (steady), 0 = tail mode (PWM) |
| pwm_on | input | 1 | Tail PWM on-phase |
| supply_ok | input | 1 | Supply above the open-load disable threshold |
| uvlo | input | 1 | Supply below the under-voltage lockout level |
| diag_reset | input | 1 | Diagnostic pin pulled below its reset level |
| chan_open | input | NCH | Per-channel open-string flags |
| chan_grounded | input | NCH | Per-channel grounded (unused) flags |
| chain_open | input | 1 | Chained sequence output found open |
| thermal | input | 1 | Over-temperature fault |
| bias_fault | input | 1 | Current-programming limit fault |
| all_off | output | 1 | Turn every channel off |
| diag_high | output | 1 | Diagnostic flag, 1 = fault |

## Verification
The two events that can fall in the same cycle are a latch clear and a qualified open string that is still present. The bench provokes this by keeping a channel open while the block is latched off, then pulsing `diag_reset` for one cycle. Two edges later it expects both outputs low, because the clear has priority and also empties the qualification counters. After one more qualification window it expects `all_off` high again. A design that let the still-qualified open re-set the latch on the clearing cycle would fail the first check.

// File: rtl/osg_pkg.sv
package osg_pkg;

  // Sources that can drive the diagnostic flag high.
  typedef struct packed {
    logic disabled;
    logic thermal;
    logic bias;
    logic latched;
    logic open_rep;
  } osg_diag_src_t;

  function automatic logic diag_level(input osg_diag_src_t s, input logic stop_mode,
                                      input logic pwm_phase);
    return s.disabled | s.thermal | s.bias | s.latched |
           (s.open_rep & (stop_mode | pwm_phase));
  endfunction

endpackage

// File: rtl/osg_tick.sv
module osg_tick #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/osg_qual.sv
module osg_qual #(
  parameter int unsigned QUAL_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic raw,
  output logic qual
);

  localparam int unsigned QW = $clog2(QUAL_TICKS + 1);

  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_d;

  assign qual = (cnt_q == QW'(QUAL_TICKS));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !raw)      cnt_d = '0;
    else if (tick && !qual)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_drop_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !qual);

  assert_qual_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> $past(raw));

endmodule

// File: rtl/osg_latch.sv
module osg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic open_any,
  input  logic enable_n,
  input  logic diag_reset,
  input  logic uvlo,
  output logic latched,
  output logic clear_evt
);

  logic en_prev_q;
  logic latched_d;
  logic en_toggle;

  always_comb begin
    en_toggle = enable_n ^ en_prev_q;
    clear_evt = diag_reset | en_toggle | uvlo;
    latched_d = latched;
    if (clear_evt)            latched_d = 1'b0;
    else if (arm && open_any) latched_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      en_prev_q <= 1'b1;
    end else begin
      latched   <= latched_d;
      en_prev_q <= enable_n;
    end
  end

  assert_diag_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    diag_reset |=> !latched);

  assert_uvlo_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !latched);

  assert_latch_needs_option_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(arm));

endmodule

// File: rtl/openstring_guard.sv
module openstring_guard #(
  parameter int unsigned NCH        = 8,
  parameter int unsigned TICK_DIV   = 100000,
  parameter int unsigned QUAL_TICKS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_n,
  input  logic           latch_off_n,
  input  logic           stop,
  input  logic           pwm_on,
  input  logic           supply_ok,
  input  logic           uvlo,
  input  logic           diag_reset,
  input  logic [NCH-1:0] chan_open,
  input  logic [NCH-1:0] chan_grounded,
  input  logic           chain_open,
  input  logic           thermal,
  input  logic           bias_fault,
  output logic           all_off,
  output logic           diag_high
);

  import osg_pkg::*;

  localparam int unsigned NSRC = NCH + 1;

  logic            ms_tick;
  logic            mask_arm_q, mask_arm_d;
  logic [NCH-1:0]  mask_q, mask_d;
  logic            det_active;
  logic [NSRC-1:0] raw_src;
  logic [NSRC-1:0] qual_src;
  logic            open_any;
  logic            latched;
  logic            clear_evt;
  logic            all_off_d;
  logic            diag_d;
  osg_diag_src_t   dsrc;

  // Grounded-channel mask, captured once per power-up.
  always_comb begin
    mask_arm_d = mask_arm_q;
    mask_d     = mask_q;
    if (uvlo) begin
      mask_arm_d = 1'b1;
      mask_d     = '0;
    end else if (mask_arm_q && supply_ok) begin
      mask_arm_d = 1'b0;
      mask_d     = chan_grounded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_arm_q <= 1'b1;
      mask_q     <= '0;
    end else begin
      mask_arm_q <= mask_arm_d;
      mask_q     <= mask_d;
    end
  end

  assign det_active = supply_ok & ~uvlo & ~mask_arm_q & ~enable_n;
  assign raw_src    = {chain_open & det_active, chan_open & ~mask_q & {NCH{det_active}}};

  osg_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ms_tick)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_qual
    osg_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ms_tick),
      .restart (clear_evt),
      .raw     (raw_src[g]),
      .qual    (qual_src[g])
    );
  end

  assign open_any = |qual_src;

  osg_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (~latch_off_n),
    .open_any   (open_any),
    .enable_n   (enable_n),
    .diag_reset (diag_reset),
    .uvlo       (uvlo),
    .latched    (latched),
    .clear_evt  (clear_evt)
  );

  always_comb begin
    dsrc.disabled = enable_n;
    dsrc.thermal  = thermal;
    dsrc.bias     = bias_fault;
    dsrc.latched  = latched;
    dsrc.open_rep = open_any;
    all_off_d     = enable_n | thermal | latched;
    diag_d        = diag_level(dsrc, stop, pwm_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_off   <= 1'b1;
      diag_high <= 1'b1;
    end else begin
      all_off   <= all_off_d;
      diag_high <= diag_d;
    end
  end

  assert_disabled_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable_n |=> (all_off && diag_high));

  assert_thermal_kills_R12: assert property (@(posedge clk) disable iff (!rst_n)
    thermal |=> (all_off && diag_high));

  assert_bias_reports_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bias_fault |=> diag_high);

  assert_mask_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_arm_q && !uvlo) |=> $stable(mask_q));

  assert_tail_offphase_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_n && !thermal && !bias_fault && !latched && !stop && !pwm_on) |=> !diag_high);

endmodule

// File: tb/openstring_guard_test.sv
module openstring_guard_test;

  localparam int unsigned NCH  = 8;
  localparam int unsigned DIV  = 10;
  localparam int unsigned QT   = 2;
  localparam int unsigned EARLY = (QT - 1) * DIV - 2;
  localparam int unsigned LATE  = QT * DIV + 4;

  logic clk = 1'b0;
  logic rst_n;
  logic enable_n, latch_off_n, stop, pwm_on, supply_ok, uvlo, diag_reset;
  logic [NCH-1:0] chan_open, chan_grounded;
  logic chain_open, thermal, bias_fault;
  logic all_off, diag_high;

  always #2.5 clk = ~clk;

  openstring_guard #(.NCH(NCH), .TICK_DIV(DIV), .QUAL_TICKS(QT)) uut (
    .clk(clk), .rst_n(rst_n), .enable_n(enable_n), .latch_off_n(latch_off_n),
    .stop(stop), .pwm_on(pwm_on), .supply_ok(supply_ok), .uvlo(uvlo),
    .diag_reset(diag_reset), .chan_open(chan_open), .chan_grounded(chan_grounded),
    .chain_open(chain_open), .thermal(thermal), .bias_fault(bias_fault),
    .all_off(all_off), .diag_high(diag_high)
  );

  typedef struct {
    logic  off;
    logic  diag;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic expect_out(input logic off, input logic diag, input string req);
    exp_t e;
    e.off = off; e.diag = diag; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expectations and compares against the outputs.
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      n_cmp++;
      if (all_off !== e.off || diag_high !== e.diag) begin
        n_bad++;
        $display("FAIL %s: all_off/diag_high = %b/%b, expected %b/%b",
                 e.req, all_off, diag_high, e.off, e.diag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable_n = 1'b1; latch_off_n = 1'b1; stop = 1'b1; pwm_on = 1'b0;
    supply_ok = 1'b0; uvlo = 1'b1; diag_reset = 1'b0; chan_open = '0;
    chan_grounded = '0; chain_open = 1'b0; thermal = 1'b0; bias_fault = 1'b0;
    cycles(3);
    expect_out(1'b1, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    cycles(1);
    expect_out(1'b1, 1'b1, "R1 after reset");

    // R2: disabled state ignores faults
    bias_fault = 1'b1; chan_open = 8'h0F;
    cycles(3);
    expect_out(1'b1, 1'b1, "R2 disabled");
    bias_fault = 1'b0; chan_open = '0;

    // Power up with channel 7 grounded, supply still low
    uvlo = 1'b0; enable_n = 1'b0; chan_grounded = 8'h80;
    cycles(2);
    expect_out(1'b0, 1'b0, "R4 enabled idle");
    chan_open = 8'h01;
    cycles(LATE * 2);
    expect_out(1'b0, 1'b0, "R4 open ignored below threshold");
    chan_open = '0;
    supply_ok = 1'b1;
    cycles(2);
    chan_grounded = '0;
    chan_open = 8'h80;
    cycles(LATE * 2);
    expect_out(1'b0, 1'b0, "R5 grounded channel masked");
    chan_open = '0;
    cycles(2);

    // R3 / R7 / R11: report without latch
    chan_open = 8'h04;
    cycles(EARLY);
    expect_out(1'b0, 1'b0, "R3 not yet qualified");
    cycles(LATE - EARLY);
    expect_out(1'b0, 1'b1, "R7 reported, outputs kept on");
    stop = 1'b0; pwm_on = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R11 tail off-phase");
    pwm_on = 1'b1;
    cycles(2);
    expect_out(1'b0, 1'b1, "R11 tail on-phase");
    pwm_on = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R11 tail off-phase again");
    stop = 1'b1;
    cycles(2);
    expect_out(1'b0, 1'b1, "R11 stop steady");
    chan_open = '0;
    cycles(3);
    expect_out(1'b0, 1'b0, "R7 report gone");
    for (int k = 0; k < 4; k++) begin
      chan_open = 8'h02;
      cycles(EARLY - 2);
      chan_open = '0;
      cycles(1);
    end
    expect_out(1'b0, 1'b0, "R3 interrupted open restarts");

    // R6: latch-off
    latch_off_n = 1'b0;
    chan_open = 8'h08;
    cycles(LATE);
    expect_out(1'b1, 1'b1, "R6 latched off");
    chan_open = '0;
    cycles(LATE * 2);
    expect_out(1'b1, 1'b1, "R6 sticky after open removed");

    // R8: diag reset
    diag_reset = 1'b1;
    cycles(1);
    diag_reset = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R8 cleared");
    chan_open = 8'h08;
    cycles(LATE);
    expect_out(1'b1, 1'b1, "R8 relatched");
    diag_reset = 1'b1;
    cycles(1);
    diag_reset = 1'b0;
    cycles(1);
    expect_out(1'b0, 1'b0, "R8 clear wins over persisting open");
    cycles(EARLY - 2);
    expect_out(1'b0, 1'b0, "R8 requalification pending");
    cycles(LATE);
    expect_out(1'b1, 1'b1, "R8 relatch after requalify");

    // R9: enable toggle
    chan_open = '0;
    enable_n = 1'b1;
    cycles(1);
    enable_n = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R9 enable toggle clears");

    // R13 then R10
    chain_open = 1'b1;
    cycles(LATE);
    expect_out(1'b1, 1'b1, "R13 chain open latches");
    chain_open = 1'b0;
    uvlo = 1'b1;
    cycles(2);
    uvlo = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R10 uvlo clears");
    latch_off_n = 1'b1;
    chan_open = 8'h80;
    cycles(LATE);
    expect_out(1'b0, 1'b1, "R5 mask re-armed after uvlo");
    chan_open = '0;
    cycles(3);

    // R12
    thermal = 1'b1;
    cycles(2);
    expect_out(1'b1, 1'b1, "R12 thermal");
    thermal = 1'b0; bias_fault = 1'b1;
    cycles(2);
    expect_out(1'b0, 1'b1, "R12 bias");
    bias_fault = 1'b0;
    cycles(2);
    expect_out(1'b0, 1'b0, "R12 faults cleared");

    wait (exp_q.size() == 0);
    cycles(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule